// File: doc/BRIEF.md
# Host-Settable Device Timestamp Unit

This block keeps a 64-bit time value on the device side. After reset the value is unknown to the device, and a read reports zero. When the host writes its own notion of the current time, the block stores that value. At the same moment it also stores the reading of a local tick counter. The tick counter advances once per nanosecond-equivalent enable pulse.

Every later read reports the host-supplied value plus the ticks that have passed since the write. The sum wraps at 2^64. A later write replaces both stored values.

Requests arrive as single-cycle strobes that carry a declared input payload length. Each request is answered one cycle later with a one-cycle completion pulse, a status code, the output payload length and the 64-bit result. A request whose declared length is wrong is rejected and changes no state.

Top module: `htime_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `done` is 0, `status` is 0, `out_len` is 0, `out_data` is 0 and `time_valid` is 0.
- R2: A read (`get_req` with `get_len` = 0) made before any successful write completes with `status` = 0 (OK), `out_len` = 8 and `out_data` = 0.
- R3: A write (`set_req` with `set_len` = 8) completes with `status` = 0, `out_len` = 0 and `out_data` = 0, and from then on `time_valid` is 1.
- R4: A read after a write returns the written value plus the number of clock edges with `tick_en` high that lie from the write's request edge up to, but not including, the read's request edge.
- R5: The read result is computed modulo 2^64, so a written value near 2^64-1 wraps through zero.
- R6: A second write fully replaces the stored host value and restarts the elapsed-tick count from its own request edge.
- R7: The tick counter advances only on edges where `tick_en` is 1, so reads separated by edges with `tick_en` low return the same value.
- R8: `done` is 1 for exactly the cycle after each edge that has `get_req` or `set_req` high, and 0 otherwise.
- R9: When `get_req` and `set_req` are both high on the same edge, only the write is performed. It completes with `out_len` = 0, and no read result is produced.
- R10: A write with `set_len` other than 8, or a read with `get_len` other than 0, completes with `status` = 1 (bad length), `out_len` = 0 and `out_data` = 0, and leaves the stored time and `time_valid` unchanged.
- R11: `time_valid` is sticky: once set by a successful write, it stays 1 until reset.
- R12: The result is a little-endian byte payload: payload byte i is carried on `out_data[8*i+7:8*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Nanosecond-equivalent enable for the tick counter |
| get_req | input | 1 | Read request strobe |
| get_len | input | 16 | Declared input payload length of the read, in bytes |
| set_req | input | 1 | Write request strobe |
| set_len | input | 16 | Declared input payload length of the write, in bytes |
| set_data | input | 64 | Host time carried by the write |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 = OK, 1 = bad payload length |
| out_len | output | 16 | Output payload length, in bytes |
| out_data | output | 64 | Output payload, byte i in bits 8i+7:8i |
| time_valid | output | 1 | High once the host has set the time |

## Verification
Reads are issued before any write, right after a write with the tick enable held high, and after a counted burst of enable pulses with the enable otherwise low. Together these separate a zero report from an extrapolated one and show that the elapsed count comes from the write's capture point rather than from reset. A write near the top of the 64-bit range shows the wrap. Two writes back to back show that both the value and the capture are replaced. Simultaneous requests and mis-sized lengths show the priority rule and the rejection path, and a follow-up read confirms in each case that the stored time is unchanged.

// File: rtl/htime_pkg.sv
package htime_pkg;
  localparam int TIME_W = 64;
  localparam int LEN_W  = 16;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BAD_LEN = 2'd1
  } htime_status_e;

  // Ticks elapsed between a captured count and the present count.
  function automatic logic [TIME_W-1:0] ticks_since(input logic [TIME_W-1:0] now,
                                                    input logic [TIME_W-1:0] cap);
    return now - cap;
  endfunction

  // Host value advanced by a tick delta, modulo 2^TIME_W.
  function automatic logic [TIME_W-1:0] extrapolate(input logic [TIME_W-1:0] host,
                                                    input logic [TIME_W-1:0] delta);
    return host + delta;
  endfunction
endpackage

// File: rtl/htime_tick_ctr.sv
module htime_tick_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (tick_en) count <= count + 1'b1;
  end
endmodule

// File: rtl/htime_store.sv
module htime_store #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_fire,
  input  logic [W-1:0] host_in,
  input  logic [W-1:0] tick_now,
  output logic         valid,
  output logic [W-1:0] host_q,
  output logic [W-1:0] cap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      host_q <= '0;
      cap_q  <= '0;
    end else if (set_fire) begin
      valid  <= 1'b1;
      host_q <= host_in;
      cap_q  <= tick_now;
    end
  end
endmodule

// File: rtl/htime_resp.sv
module htime_resp
  import htime_pkg::*;
#(
  parameter int W = 64,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          get_fire,
  input  logic          set_fire,
  input  logic          len_err,
  input  logic          valid,
  input  logic [W-1:0]  host_q,
  input  logic [W-1:0]  cap_q,
  input  logic [W-1:0]  tick_now,
  output logic          done,
  output logic [1:0]    status,
  output logic [LW-1:0] out_len,
  output logic [W-1:0]  out_data
);
  localparam int PAY_BYTES = W / 8;
  localparam logic [LW-1:0] GET_OUT_LEN = LW'(PAY_BYTES);

  logic [W-1:0] now_time;
  logic [W-1:0] word_le;

  always_comb begin
    now_time = valid ? extrapolate(host_q, ticks_since(tick_now, cap_q)) : '0;
  end

  // Place each byte of the time value in ascending payload byte order.
  for (genvar b = 0; b < PAY_BYTES; b++) begin : g_byte
    assign word_le[8*b +: 8] = now_time[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= ST_OK;
      out_len  <= '0;
      out_data <= '0;
    end else begin
      done     <= get_fire | set_fire | len_err;
      status   <= len_err ? ST_BAD_LEN : ST_OK;
      out_len  <= get_fire ? GET_OUT_LEN : '0;
      out_data <= get_fire ? word_le : '0;
    end
  end
endmodule

// File: rtl/htime_unit.sv
module htime_unit
  import htime_pkg::*;
#(
  parameter int W  = TIME_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          get_req,
  input  logic [LW-1:0] get_len,
  input  logic          set_req,
  input  logic [LW-1:0] set_len,
  input  logic [W-1:0]  set_data,
  output logic          done,
  output logic [1:0]    status,
  output logic [LW-1:0] out_len,
  output logic [W-1:0]  out_data,
  output logic          time_valid
);
  localparam logic [LW-1:0] SET_IN_LEN = LW'(W / 8);
  localparam logic [LW-1:0] GET_IN_LEN = '0;

  // Named internal events, also watched by the checker.
  logic set_fire;
  logic get_fire;
  logic len_err;
  logic [W-1:0] tick_now;
  logic [W-1:0] host_q;
  logic [W-1:0] cap_q;

  always_comb begin
    set_fire = set_req && (set_len == SET_IN_LEN);
    get_fire = get_req && !set_req && (get_len == GET_IN_LEN);
    len_err  = set_req ? (set_len != SET_IN_LEN)
                       : (get_req && (get_len != GET_IN_LEN));
  end

  htime_tick_ctr #(.W(W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .count  (tick_now)
  );

  htime_store #(.W(W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_fire(set_fire),
    .host_in (set_data),
    .tick_now(tick_now),
    .valid   (time_valid),
    .host_q  (host_q),
    .cap_q   (cap_q)
  );

  htime_resp #(.W(W), .LW(LW)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .get_fire(get_fire),
    .set_fire(set_fire),
    .len_err (len_err),
    .valid   (time_valid),
    .host_q  (host_q),
    .cap_q   (cap_q),
    .tick_now(tick_now),
    .done    (done),
    .status  (status),
    .out_len (out_len),
    .out_data(out_data)
  );
endmodule

// File: rtl/htime_unit_chk.sv
module htime_unit_chk #(
  parameter int W  = 64,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          get_req,
  input logic          set_req,
  input logic          set_fire,
  input logic          get_fire,
  input logic          len_err,
  input logic          done,
  input logic [1:0]    status,
  input logic [LW-1:0] out_len,
  input logic [W-1:0]  out_data,
  input logic          time_valid
);
  // R8: completion follows each request edge by exactly one cycle
  p_done_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (get_req || set_req) |=> done);
  p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(get_req || set_req) |=> !done);
  // R11: the set flag never drops outside reset
  p_valid_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |=> time_valid);
  // R3: a successful write raises the flag and returns an empty payload
  p_set_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire |=> (time_valid && out_len == '0 && out_data == '0));
  // R9: a read is never performed alongside a write
  p_set_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_fire && get_fire));
  // R10: a rejected request leaves no payload and no new flag
  p_bad_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> (status == 2'd1 && out_len == '0 && out_data == '0
                 && time_valid == $past(time_valid)));
  // R2: before any write a read result is zero
  p_unset_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (get_fire && !time_valid) |=> (out_data == '0 && out_len == LW'(W / 8)));
endmodule

bind htime_unit htime_unit_chk #(.W(W), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .get_req   (get_req),
  .set_req   (set_req),
  .set_fire  (set_fire),
  .get_fire  (get_fire),
  .len_err   (len_err),
  .done      (done),
  .status    (status),
  .out_len   (out_len),
  .out_data  (out_data),
  .time_valid(time_valid)
);

// File: tb/tb_htime_unit.sv
module tb_htime_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        get_req = 1'b0;
  logic [15:0] get_len = '0;
  logic        set_req = 1'b0;
  logic [15:0] set_len = '0;
  logic [63:0] set_data = '0;
  logic        done;
  logic [1:0]  status;
  logic [15:0] out_len;
  logic [63:0] out_data;
  logic        time_valid;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  htime_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .get_req(get_req), .get_len(get_len),
    .set_req(set_req), .set_len(set_len), .set_data(set_data),
    .done(done), .status(status), .out_len(out_len),
    .out_data(out_data), .time_valid(time_valid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request on the next edge; outputs are sampled one negedge later.
  task automatic issue(input bit g, input logic [15:0] gl, input bit s,
                       input logic [15:0] sl, input logic [63:0] d);
    get_req = g; get_len = gl; set_req = s; set_len = sl; set_data = d;
    @(negedge clk);
    get_req = 1'b0; set_req = 1'b0; get_len = '0; set_len = '0;
  endtask

  task automatic pulse_ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 status", status, 0);
    chk("R1 out_len", out_len, 0);
    chk("R1 out_data", out_data, 0);
    chk("R1 valid", time_valid, 0);
  endtask

  task automatic t_get_unset;
    pulse_ticks(7);
    issue(1, 0, 0, 0, 0);
    chk("R2 done", done, 1);
    chk("R2 status", status, 0);
    chk("R2 len", out_len, 8);
    chk("R2 data", out_data, 0);
    @(negedge clk);
    chk("R8 done low", done, 0);
  endtask

  task automatic t_set_then_counted;
    issue(0, 0, 1, 8, 64'h0000_1000_0000_0000);
    chk("R3 done", done, 1);
    chk("R3 len", out_len, 0);
    chk("R3 data", out_data, 0);
    chk("R3 valid", time_valid, 1);
    pulse_ticks(13);
    issue(1, 0, 0, 0, 0);
    chk("R4 counted", out_data, 64'h0000_1000_0000_000D);
    chk("R12 byte0", out_data[7:0], 8'h0D);
    chk("R12 byte5", out_data[47:40], 8'h10);
    repeat (4) @(negedge clk);
    issue(1, 0, 0, 0, 0);
    chk("R7 idle stable", out_data, 64'h0000_1000_0000_000D);
  endtask

  task automatic t_continuous;
    tick_en = 1'b1;
    issue(0, 0, 1, 8, 64'h55);
    issue(1, 0, 0, 0, 0);
    chk("R4 one edge", out_data, 64'h56);
    repeat (2) @(negedge clk);
    issue(1, 0, 0, 0, 0);
    chk("R4 four edges", out_data, 64'h59);
    tick_en = 1'b0;
  endtask

  task automatic t_wrap;
    issue(0, 0, 1, 8, 64'hFFFF_FFFF_FFFF_FFFD);
    pulse_ticks(5);
    issue(1, 0, 0, 0, 0);
    chk("R5 wrap", out_data, 64'h2);
  endtask

  task automatic t_reset_replace;
    issue(0, 0, 1, 8, 64'hAAAA);
    pulse_ticks(9);
    issue(0, 0, 1, 8, 64'h100);
    pulse_ticks(2);
    issue(1, 0, 0, 0, 0);
    chk("R6 replaced", out_data, 64'h102);
  endtask

  task automatic t_both;
    issue(1, 0, 1, 8, 64'h7000);
    chk("R9 done", done, 1);
    chk("R9 len", out_len, 0);
    chk("R9 data", out_data, 0);
    issue(1, 0, 0, 0, 0);
    chk("R9 write taken", out_data, 64'h7000);
  endtask

  task automatic t_bad_len;
    issue(0, 0, 1, 4, 64'h1234);
    chk("R10 set status", status, 1);
    chk("R10 set len", out_len, 0);
    chk("R10 set done", done, 1);
    issue(1, 3, 0, 0, 0);
    chk("R10 get status", status, 1);
    chk("R10 get data", out_data, 0);
    issue(1, 0, 0, 0, 0);
    chk("R10 unchanged", out_data, 64'h7000);
    chk("R10 ok status", status, 0);
    chk("R11 sticky", time_valid, 1);
  endtask

  task automatic t_bad_first;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    issue(0, 0, 1, 9, 64'h99);
    chk("R10 no valid", time_valid, 0);
    issue(1, 0, 0, 0, 0);
    chk("R10 still zero", out_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_get_unset;
    t_set_then_counted;
    t_continuous;
    t_wrap;
    t_reset_replace;
    t_both;
    t_bad_len;
    t_bad_first;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule